// File: doc/BRIEF.md
# Scanning Window-Alarm Monitor

The block steps through a set of input channels and asks an external converter for one 12-bit sample at a time. Requests are paced by a programmable timer. Each returned sample is compared against a lower and an upper limit that belong to the sampled channel. A sample outside that window raises a sticky alarm bit for the channel. The alarm bits are visible at all times as a status word. Software clears them per channel.

The converter is modelled as a simple handshake. The block presents a one-cycle request pulse together with a channel number. The converter later answers with a one-cycle result-valid pulse and the sample. Only one conversion is ever in flight.

Three settings shape the scan:
- The highest channel to visit.
- A paired (differential) mode, in which only the even member of each pair is sampled.
- A 3-bit rate code that stretches the request interval by a power of two.

An interrupt output enable asserts only when interrupts are enabled and at least one alarm is latched. Otherwise the open-drain line is released.

Top module: `scan_window_monitor`

## Requirements
- R1: With rate code c, and a result that returns before the interval runs out, successive requests are exactly BASE_TICKS×2^c cycles apart. With BASE_TICKS = 4, code 0 gives 4 cycles, code 3 gives 32 and code 7 gives 512. Each request is a single-cycle pulse.
- R2: No new request is issued while a result is outstanding. If the result takes longer than the interval, the next request follows in the cycle after the result arrives. A result-valid pulse with no outstanding request is ignored.
- R3: In single-ended mode, the channels 0 up to the selected highest channel are requested in ascending order, and the scan wraps to channel 0. Channels above the selected one are never requested.
- R4: In differential mode, only even channels are requested. The sample uses the even channel's limits and sets the even channel's alarm bit. Odd alarm bits are not touched.
- R5: A sample sets its channel's alarm when, read as signed two's complement, it is strictly below the lower limit or strictly above the upper limit. A sample equal to either limit does not set the alarm.
- R6: A lower limit of 0x800 with an upper limit of 0x7FF never sets the alarm, whatever the sample.
- R7: An alarm bit stays set until its clear bit is pulsed, even if later samples are inside the window. If a clear and a new violation occur in the same cycle, the violation wins.
- R8: The interrupt output enable is high exactly when interrupts are enabled and at least one alarm bit is set.
- R9: The alarm status word reflects the latched alarms regardless of the interrupt enable.
- R10: Synchronous active-low reset clears all alarms, drops the request and releases the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_rate_code | input | CODE_W | Rate code; interval = BASE_TICKS×2^code cycles |
| cfg_diff | input | 1 | 1 = paired mode, even channels only |
| cfg_last_ch | input | CH_W | Highest channel in the scan |
| cfg_irq_en | input | 1 | Interrupt enable |
| thr_lo_flat | input | NUM_CH×DATA_W | Signed lower limits, channel i at bits [i×DATA_W +: DATA_W] |
| thr_hi_flat | input | NUM_CH×DATA_W | Signed upper limits, same packing |
| alarm_clr | input | NUM_CH | Per-channel alarm clear pulse |
| conv_req | output | 1 | Conversion request pulse |
| conv_ch | output | CH_W | Channel of the request |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | DATA_W | Conversion result |
| alarm_status | output | NUM_CH | Latched alarm bits |
| irq_oe | output | 1 | Interrupt line drive enable (line pulled low when 1) |

## Verification
A behavioural model predicts every output on every clock. It is driven through several distinct patterns:
- In-window samples, which separate a correct compare from one that alarms spuriously.
- Samples exactly on each limit and one step beyond, which separate strict from inclusive compares.
- An inverted extreme window, which exposes an unsigned compare.
- Slow converter answers and stray result strobes, which test the single-outstanding rule.

Rate codes 0, 3 and 7 are timed between requests. Paired mode and a reduced channel range are checked by counting which channels are ever requested.

// File: rtl/mon_pkg.sv
// Package: shared types and helpers for the scanning window-alarm monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package mon_pkg;

    // Sequencer state: waiting for the rate timer, or waiting for a result
    typedef enum logic {
        SEQ_WAIT        = 1'b0,
        SEQ_OUTSTANDING = 1'b1
    } seq_state_e;

    // Longest interval the rate timer must be able to count
    function automatic int unsigned rate_max_ticks(int unsigned base, int unsigned code_w);
        return base << ((1 << code_w) - 1);
    endfunction

endpackage

// File: rtl/mon_rate_timer.sv
// Module: mon_rate_timer
// Counts cycles since the last request and flags when the programmed
// interval (BASE_TICKS << code) has elapsed. The count saturates at the
// interval, so a late request is issued as soon as it is allowed.
// Assumes: restart is the request pulse; BASE_TICKS >= 1.
module mon_rate_timer #(
    parameter int BASE_TICKS = 4,
    parameter int CODE_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              restart,
    output logic              due
);
    localparam int unsigned MAX_TICKS = mon_pkg::rate_max_ticks(BASE_TICKS, CODE_W);
    localparam int          CNT_W     = $clog2(MAX_TICKS + 1);

    logic [31:0]      ival;
    logic [CNT_W-1:0] interval_m1;
    logic [CNT_W-1:0] cnt_q;

    // Interval length for the current code, minus one
    always_comb begin
        ival        = 32'(BASE_TICKS) << cfg_code;
        interval_m1 = CNT_W'(ival - 32'd1);
    end

    // Cycle counter: cleared on request, saturating at the interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q < interval_m1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign due = (cnt_q >= interval_m1);

endmodule

// File: rtl/mon_scan_seq.sv
// Module: mon_scan_seq
// Issues one conversion request at a time, in ascending channel order,
// and tracks the channel whose result is outstanding. In paired mode the
// channel LSB is forced low, so only even channels are visited.
// Assumes: the converter answers each request with exactly one res_valid.
module mon_scan_seq #(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            due,
    input  logic            cfg_diff,
    input  logic [CH_W-1:0] cfg_last_ch,
    input  logic            res_valid,
    output logic            conv_req,
    output logic [CH_W-1:0] conv_ch,
    output logic            res_take,
    output logic [CH_W-1:0] res_ch
);
    import mon_pkg::*;

    seq_state_e      state_q;
    logic [CH_W-1:0] cur_q;
    logic [CH_W-1:0] pend_q;
    logic [CH_W-1:0] masked_ch;
    logic [CH_W-1:0] issue_ch;
    logic [CH_W:0]   nxt_wide;
    logic [CH_W-1:0] next_ch;

    // Channel to issue now, and the channel after it with wrap
    always_comb begin
        masked_ch = cur_q;
        if (cfg_diff) masked_ch[0] = 1'b0;
        issue_ch = (masked_ch > cfg_last_ch) ? '0 : masked_ch;
        nxt_wide = {1'b0, issue_ch} + (cfg_diff ? (CH_W+1)'(2) : (CH_W+1)'(1));
        next_ch  = (nxt_wide > {1'b0, cfg_last_ch}) ? '0 : nxt_wide[CH_W-1:0];
    end

    assign conv_req = due && (state_q == SEQ_WAIT);
    assign conv_ch  = issue_ch;
    assign res_take = res_valid && (state_q == SEQ_OUTSTANDING);
    assign res_ch   = pend_q;

    // Request/result state and the scan pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_WAIT;
            cur_q   <= '0;
            pend_q  <= '0;
        end else if (conv_req) begin
            state_q <= SEQ_OUTSTANDING;
            pend_q  <= issue_ch;
            cur_q   <= next_ch;
        end else if (res_take) begin
            state_q <= SEQ_WAIT;
        end
    end

    // R2: a request is one cycle wide and is never repeated back to back
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R2: no request may appear while a result is still owed
    a_r2_no_req_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req || (state_q == SEQ_OUTSTANDING && !res_valid)) |=> !conv_req);

endmodule

// File: rtl/mon_window_bank.sv
// Module: mon_window_bank
// One signed window compare and one sticky alarm bit per channel. An
// accepted result is checked only against its own channel's limits. A
// violation in the same cycle as a clear keeps the bit set.
// Assumes: res_take is high for one cycle per accepted result.
module mon_window_bank #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 12,
    parameter int CH_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_take,
    input  logic [CH_W-1:0]          res_ch,
    input  logic [DATA_W-1:0]        res_data,
    input  logic [NUM_CH*DATA_W-1:0] thr_lo_flat,
    input  logic [NUM_CH*DATA_W-1:0] thr_hi_flat,
    input  logic [NUM_CH-1:0]        alarm_clr,
    output logic [NUM_CH-1:0]        alarm_q
);
    logic [NUM_CH-1:0] viol;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic signed [DATA_W-1:0] lo_s;
        logic signed [DATA_W-1:0] hi_s;
        logic signed [DATA_W-1:0] smp_s;

        // Signed compare of the result against this channel's window
        always_comb begin
            lo_s    = thr_lo_flat[i*DATA_W +: DATA_W];
            hi_s    = thr_hi_flat[i*DATA_W +: DATA_W];
            smp_s   = res_data;
            viol[i] = res_take && (res_ch == CH_W'(i)) && ((smp_s < lo_s) || (smp_s > hi_s));
        end

        // Sticky alarm: cleared on request, set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alarm_q[i] <= 1'b0;
            end else begin
                alarm_q[i] <= (alarm_q[i] & ~alarm_clr[i]) | viol[i];
            end
        end

        // R7: a set alarm survives any cycle without a clear
        a_r7_alarm_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (alarm_q[i] && !alarm_clr[i]) |=> alarm_q[i]);

        // R7: a clear without a competing violation takes effect
        a_r7_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
            (alarm_clr[i] && !viol[i]) |=> !alarm_q[i]);

        // R6: the inverted extreme window can never flag a violation
        a_r6_open_window: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_lo_flat[i*DATA_W +: DATA_W] == {1'b1, {(DATA_W-1){1'b0}}} &&
             thr_hi_flat[i*DATA_W +: DATA_W] == {1'b0, {(DATA_W-1){1'b1}}}) |-> !viol[i]);
    end

endmodule

// File: rtl/scan_window_monitor.sv
// Module: scan_window_monitor (top)
// Paces conversion requests with the rate timer, walks the channels with
// the sequencer, and latches window alarms in the compare bank. The
// interrupt drive enable follows the enable and the alarm word.
// Assumes: one conversion in flight; limits are signed two's complement.
module scan_window_monitor #(
    parameter int NUM_CH     = 4,
    parameter int DATA_W     = 12,
    parameter int CODE_W     = 3,
    parameter int BASE_TICKS = 4,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CODE_W-1:0]        cfg_rate_code,
    input  logic                     cfg_diff,
    input  logic [CH_W-1:0]          cfg_last_ch,
    input  logic                     cfg_irq_en,
    input  logic [NUM_CH*DATA_W-1:0] thr_lo_flat,
    input  logic [NUM_CH*DATA_W-1:0] thr_hi_flat,
    input  logic [NUM_CH-1:0]        alarm_clr,
    output logic                     conv_req,
    output logic [CH_W-1:0]          conv_ch,
    input  logic                     res_valid,
    input  logic [DATA_W-1:0]        res_data,
    output logic [NUM_CH-1:0]        alarm_status,
    output logic                     irq_oe
);
    logic            due;
    logic            res_take;
    logic [CH_W-1:0] res_ch;

    mon_rate_timer #(
        .BASE_TICKS (BASE_TICKS),
        .CODE_W     (CODE_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_code (cfg_rate_code),
        .restart  (conv_req),
        .due      (due)
    );

    mon_scan_seq #(
        .CH_W (CH_W)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .due         (due),
        .cfg_diff    (cfg_diff),
        .cfg_last_ch (cfg_last_ch),
        .res_valid   (res_valid),
        .conv_req    (conv_req),
        .conv_ch     (conv_ch),
        .res_take    (res_take),
        .res_ch      (res_ch)
    );

    mon_window_bank #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_take    (res_take),
        .res_ch      (res_ch),
        .res_data    (res_data),
        .thr_lo_flat (thr_lo_flat),
        .thr_hi_flat (thr_hi_flat),
        .alarm_clr   (alarm_clr),
        .alarm_q     (alarm_status)
    );

    // Interrupt drive: only when enabled and some alarm is latched
    assign irq_oe = cfg_irq_en & (|alarm_status);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R5: an alarm can only rise on the edge where a result arrived
        a_r5_rise_on_result: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alarm_status[i]) |-> $past(res_valid));
    end

    // R2: a strobe while nothing is owed leaves the alarm word unchanged
    a_r2_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_take && alarm_clr == '0) |=> $stable(alarm_status));

endmodule

// File: tb/test_scan_window_monitor.sv
`timescale 1ns/1ps
module test_scan_window_monitor;
    localparam int NCH  = 4;
    localparam int DW   = 12;
    localparam int CW   = 3;
    localparam int CHW  = 2;
    localparam int BASE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0]      cfg_rate_code = '0;
    logic               cfg_diff = 1'b0;
    logic [CHW-1:0]     cfg_last_ch = 2'd3;
    logic               cfg_irq_en = 1'b0;
    logic [NCH*DW-1:0]  thr_lo_flat;
    logic [NCH*DW-1:0]  thr_hi_flat;
    logic [NCH-1:0]     alarm_clr = '0;
    logic               conv_req;
    logic [CHW-1:0]     conv_ch;
    logic               res_valid = 1'b0;
    logic [DW-1:0]      res_data = '0;
    logic [NCH-1:0]     alarm_status;
    logic               irq_oe;

    int lo_thr[NCH];
    int hi_thr[NCH];
    int adc_val[NCH];

    // reference model state
    int         m_cnt, m_cur, m_pend;
    bit         m_busy;
    bit [NCH-1:0] m_alarm;
    // responder state
    int lat_cfg = 2, lat_left = 0, lat_ch = 0;
    bit lat_act = 1'b0, stray_en = 1'b0;
    // bookkeeping
    int vectors = 0, fails = 0, cyc = 0, last_req_cyc = 0, gap = 0;
    bit req_seen;
    int req_cnt[NCH];
    string tag_alarm = "R5 alarm_status";

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            thr_lo_flat[i*DW +: DW] = DW'(lo_thr[i]);
            thr_hi_flat[i*DW +: DW] = DW'(hi_thr[i]);
        end
    end

    scan_window_monitor #(.NUM_CH(NCH), .DATA_W(DW), .CODE_W(CW), .BASE_TICKS(BASE)) i_scan_window_monitor (
        .clk(clk), .rst_n(rst_n), .cfg_rate_code(cfg_rate_code), .cfg_diff(cfg_diff),
        .cfg_last_ch(cfg_last_ch), .cfg_irq_en(cfg_irq_en), .thr_lo_flat(thr_lo_flat),
        .thr_hi_flat(thr_hi_flat), .alarm_clr(alarm_clr), .conv_req(conv_req), .conv_ch(conv_ch),
        .res_valid(res_valid), .res_data(res_data), .alarm_status(alarm_status), .irq_oe(irq_oe));

    function automatic int ivl();
        return BASE << cfg_rate_code;
    endfunction
    function automatic int issue_of(int cur);
        int c = cur;
        if (cfg_diff) c = c & ~1;
        if (c > int'(cfg_last_ch)) c = 0;
        return c;
    endfunction
    function automatic int next_of(int c);
        int n = c + (cfg_diff ? 2 : 1);
        if (n > int'(cfg_last_ch)) n = 0;
        return n;
    endfunction
    function automatic bit m_req();
        return (m_cnt >= ivl() - 1) && !m_busy;
    endfunction
    function automatic int sx(logic [DW-1:0] d);
        return int'($signed(d));
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // one clock: drive responder, advance model, then compare at the next negedge
    task automatic cycle();
        bit [NCH-1:0] setv;
        bit fire;
        int is;
        int v;
        // converter responder
        res_valid = 1'b0;
        if (lat_act) begin
            lat_left--;
            if (lat_left == 0) begin
                res_valid = 1'b1;
                res_data  = DW'(adc_val[lat_ch]);
                lat_act   = 1'b0;
            end
        end else if (stray_en && rst_n && !m_busy && !m_req()) begin
            res_valid = 1'b1;   // stray strobe, R2
            res_data  = 12'h7FF;
        end
        if (rst_n && conv_req) begin
            lat_act  = 1'b1;
            lat_left = lat_cfg;
            lat_ch   = int'(conv_ch);
        end
        // reference model
        if (!rst_n) begin
            m_cnt = 0; m_busy = 1'b0; m_cur = 0; m_pend = 0; m_alarm = '0;
        end else begin
            setv = '0;
            fire = m_req();
            is   = issue_of(m_cur);
            if (res_valid && m_busy) begin
                v = sx(res_data);
                if (v < lo_thr[m_pend] || v > hi_thr[m_pend]) setv[m_pend] = 1'b1;
            end
            m_alarm = (m_alarm & ~alarm_clr) | setv;
            if (fire) begin
                m_busy = 1'b1; m_pend = is; m_cur = next_of(is); m_cnt = 0;
            end else begin
                if (m_cnt < ivl() - 1) m_cnt++;
                if (res_valid && m_busy) m_busy = 1'b0;
            end
        end
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            summary();
        end
        req_seen = 1'b0;
        if (rst_n) begin
            check("R1 conv_req", int'(conv_req), int'(m_req()));
            if (m_req()) begin
                check("R3/R4 conv_ch", int'(conv_ch), issue_of(m_cur));
                req_cnt[issue_of(m_cur)]++;
                gap = cyc - last_req_cyc;
                last_req_cyc = cyc;
                req_seen = 1'b1;
            end
            check(tag_alarm, int'(alarm_status), int'(m_alarm));
            check("R8 irq_oe", int'(irq_oe), int'(cfg_irq_en && (|m_alarm)));
        end
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic wait_reqs(int n);
        int seen = 0;
        while (seen < n) begin
            cycle();
            if (req_seen) seen++;
        end
    endtask

    task automatic pulse_clr(logic [NCH-1:0] m);
        alarm_clr = m;
        cycle();
        alarm_clr = '0;
    endtask

    task automatic zero_counts();
        for (int i = 0; i < NCH; i++) req_cnt[i] = 0;
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            lo_thr[i] = -100; hi_thr[i] = 100; adc_val[i] = 0; req_cnt[i] = 0;
        end
        // R10: reset state
        rst_n = 1'b0;
        run(4);
        check("R10 reset conv_req", int'(conv_req), 0);
        check("R10 reset alarm_status", int'(alarm_status), 0);
        check("R10 reset irq_oe", int'(irq_oe), 0);
        rst_n = 1'b1;
        cfg_irq_en = 1'b1;

        // R3: full ascending scan, all samples inside
        zero_counts();
        run(200);
        check("R5 in-window no alarm", int'(alarm_status), 0);
        for (int i = 0; i < NCH; i++) check("R3 every channel visited", int'(req_cnt[i] > 0), 1);

        // R5: samples on the limits, then one step beyond
        adc_val[0] = -100; adc_val[1] = 100;
        run(100);
        check("R5 equal to limits", int'(alarm_status), 0);
        adc_val[3] = -101;
        run(100);
        check("R5 below lower", int'(alarm_status), 4'b1000);
        adc_val[2] = 101;
        run(100);
        check("R5 above upper", int'(alarm_status), 4'b1100);
        check("R8 irq with alarm", int'(irq_oe), 1);

        // R7: sticky until cleared, clear is per channel
        tag_alarm = "R7 alarm_status";
        adc_val[2] = 0; adc_val[3] = 0; adc_val[0] = 0; adc_val[1] = 0;
        run(100);
        check("R7 latched after return", int'(alarm_status), 4'b1100);
        pulse_clr(4'b0100);
        run(4);
        check("R7 single clear", int'(alarm_status), 4'b1000);
        pulse_clr(4'b1000);
        run(4);
        check("R7 all cleared", int'(alarm_status), 0);
        check("R8 irq released", int'(irq_oe), 0);
        // R7: clear held while violations keep arriving, set wins
        adc_val[1] = 500;
        alarm_clr = 4'b0010;
        run(300);
        alarm_clr = '0;
        adc_val[1] = 0;
        run(40);
        pulse_clr(4'b1111);
        run(40);
        check("R7 cleared after contest", int'(alarm_status), 0);

        // R6: inverted extreme window on channel 2
        tag_alarm = "R6 alarm_status";
        lo_thr[2] = -2048; hi_thr[2] = 2047;
        adc_val[2] = 2047;
        run(100);
        adc_val[2] = -2048;
        run(100);
        check("R6 extreme window silent", int'(alarm_status), 0);
        adc_val[2] = 0; lo_thr[2] = -100; hi_thr[2] = 100;

        // R2: stray strobes ignored, slow results delay the next request
        tag_alarm = "R2 alarm_status";
        stray_en = 1'b1; lat_cfg = 6;
        run(300);
        check("R2 stray strobe ignored", int'(alarm_status), 0);
        stray_en = 1'b0;
        lat_cfg = 20;
        wait_reqs(3);
        check("R2 request waits for result", gap, 21);

        // R1: request spacing for several codes
        tag_alarm = "R1 alarm_status";
        lat_cfg = 2;
        cfg_rate_code = 3'd3;
        wait_reqs(3);
        check("R1 code 3 spacing", gap, 32);
        cfg_rate_code = 3'd7;
        wait_reqs(3);
        check("R1 code 7 spacing", gap, 512);
        cfg_rate_code = 3'd0;
        wait_reqs(3);
        check("R1 code 0 spacing", gap, 4);

        // R9: status readable with the interrupt disabled
        tag_alarm = "R9 alarm_status";
        adc_val[3] = -500;
        cfg_irq_en = 1'b0;
        run(100);
        check("R9 irq released when disabled", int'(irq_oe), 0);
        check("R9 status still readable", int'(alarm_status), 4'b1000);
        cfg_irq_en = 1'b1;
        run(2);
        check("R8 irq follows enable", int'(irq_oe), 1);
        adc_val[3] = 0;
        pulse_clr(4'b1111);

        // R4: paired mode, odd channels never requested
        tag_alarm = "R4 alarm_status";
        cfg_diff = 1'b1;
        adc_val[1] = 900; adc_val[3] = -900;
        zero_counts();
        run(300);
        check("R4 channel 1 skipped", req_cnt[1], 0);
        check("R4 channel 3 skipped", req_cnt[3], 0);
        check("R4 channel 0 visited", int'(req_cnt[0] > 0), 1);
        check("R4 channel 2 visited", int'(req_cnt[2] > 0), 1);
        check("R4 odd alarms untouched", int'(alarm_status), 0);
        adc_val[2] = 900;
        run(100);
        check("R4 even pair alarm", int'(alarm_status), 4'b0100);

        // R3: single-ended, range limited to channels 0 and 1
        tag_alarm = "R3 alarm_status";
        cfg_diff = 1'b0;
        cfg_last_ch = 2'd1;
        pulse_clr(4'b1111);
        zero_counts();
        run(200);
        check("R3 channel 2 out of range", req_cnt[2], 0);
        check("R3 channel 3 out of range", req_cnt[3], 0);
        check("R3 channel 1 visited", int'(req_cnt[1] > 0), 1);
        check("R3 only channel 1 alarms", int'(alarm_status), 4'b0010);

        summary();
    end
endmodule